// File: doc/BRIEF.md
# Periodic Down-Counter Timer with Compare

This block is a 32-bit down-counting timer that sits on a simple word-addressed register bus. Its count advances on ticks from one of three clock-source strobes, picked by a control field. A prescaler divides the selected strobe by its programmed value plus one. When the count passes zero, it either restarts from a software-written load value (reload mode) or wraps to all-ones (free-running mode). When the count lands on a programmed compare value, a sticky status flag is raised, and that flag drives an interrupt line.

Software controls everything through five word registers. The bus is a plain single-cycle write strobe with a combinational read mux. Every access completes in the cycle it is presented, so there is no back-pressure and no handshake.

A few control bits change what a write does. Enable-mode decides whether switching the timer on restarts the count. The overwrite bit makes a write to the load register also replace the live count. A software-reset bit returns most of the block to its reset values and keeps the enable and low-power bits. The low-power bits are stored only.

Top module: `pdt_timer`

## Requirements
- R1: Word addresses are control = 0, status = 1, load = 2, compare = 3 and count = 4. The count register is read-only. Writes to addresses 5..7 change nothing, and reads from them return 0.
- R2: A control write stores only bits 25:0, and bits 31:26 read as 0. The control bits are: enable bit 0, enable-mode bit 1, compare-interrupt-enable bit 2, reload bit 3, prescale bits 15:4, software reset bit 16, overwrite bit 17, debug bit 18, wait bit 19, doze bit 20, stop bit 21, and clock source bits 25:24.
- R3: Clock source 01, 10 and 11 select tick input 0, 1 and 2. Source 00 selects none, and the count is frozen. With prescale value P, the count steps once for every P+1 selected ticks, counted from the moment enable is set.
- R4: Status bit 0 is the compare flag. Writing 1 to it clears the flag, and writing 0 leaves it unchanged.
- R5: The interrupt output is high exactly when the flag, compare-interrupt-enable and enable are all set.
- R6: A control write with bit 16 set does several things. Control keeps only the written bits 0, 1 and 18..21, plus bit 16. The flag clears, load becomes 0xFFFFFFFF, and compare and count become 0. Bit 16 reads back as 1 for one cycle and then clears by itself.
- R7: After hardware reset, load reads 0xFFFFFFFF, and control, status, compare, count and the interrupt read 0.
- R8: A control write that takes enable from 0 to 1 with enable-mode set restarts the count. It starts from load when reload is set and from 0xFFFFFFFF when reload is clear. With enable-mode clear, the count resumes from its held value.
- R9: While enabled, each prescaled step decrements the count. A step taken at zero loads the load value in reload mode and 0xFFFFFFFF in free-running mode.
- R10: A load write while overwrite is set also copies the value into the count in the same cycle, in either mode. With overwrite clear, the count is untouched.
- R11: The flag is set on the edge where a step or an overwrite gives the count a value equal to compare, provided enable and compare-interrupt-enable were both set before that edge.
- R12: While enable is clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| src_tick | input | 3 | Tick strobes of the three clock sources |
| irq | output | 1 | Compare interrupt, active high |

## Verification
The hardest case to reach from the ports is the step where the count passes zero. The counter would otherwise need billions of steps to get there from its all-ones start. The bench sets overwrite and writes a small load value, so the count lands a few ticks above zero. It then checks the wrap in free-running mode and the reload in reload mode. A similar shortcut sets the compare flag through an overwrite write. That flag is then used to show that software reset clears it.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = DATA_W;
  localparam int ADDR_W = 3;
  localparam int PRE_W  = 12;
  localparam int NSRC   = 3;
  localparam int SRC_W  = $clog2(NSRC + 1);

  // control bit positions
  localparam int B_EN     = 0;
  localparam int B_ENMOD  = 1;
  localparam int B_OCIEN  = 2;
  localparam int B_RLD    = 3;
  localparam int B_PRE_LO = 4;
  localparam int B_SWR    = 16;
  localparam int B_OVW    = 17;
  localparam int B_DBG    = 18;
  localparam int B_WAIT   = 19;
  localparam int B_DOZE   = 20;
  localparam int B_STOP   = 21;
  localparam int B_SRC_LO = 24;

  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h03FF_FFFF;
  localparam logic [DATA_W-1:0] SWR_KEEP  =
    (32'd1 << B_EN) | (32'd1 << B_ENMOD) | (32'd1 << B_DBG) |
    (32'd1 << B_WAIT) | (32'd1 << B_DOZE) | (32'd1 << B_STOP) | (32'd1 << B_SWR);

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 3'd0,
    RA_STAT = 3'd1,
    RA_LOAD = 3'd2,
    RA_CMP  = 3'd3,
    RA_CNT  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/pdt_regs.sv
module pdt_regs
  import pdt_pkg::*;
#(
  parameter int CNT_W_P = CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                flag_set,
  output logic [DATA_W-1:0]   ctrl_q,
  output logic [CNT_W_P-1:0]  load_q,
  output logic [CNT_W_P-1:0]  cmp_q,
  output logic                flag_q,
  output logic                start_p,
  output logic [CNT_W_P-1:0]  start_val,
  output logic                swr_p,
  output logic                ovw_p
);
  logic ctrl_wr, stat_wr, load_wr, cmp_wr;

  assign ctrl_wr = wr_en && (addr == RA_CTRL);
  assign stat_wr = wr_en && (addr == RA_STAT);
  assign load_wr = wr_en && (addr == RA_LOAD);
  assign cmp_wr  = wr_en && (addr == RA_CMP);

  assign swr_p   = ctrl_wr && wdata[B_SWR];
  assign start_p = ctrl_wr && wdata[B_EN] && !ctrl_q[B_EN] && wdata[B_ENMOD];
  assign start_val = wdata[B_RLD] ? load_q : '1;
  assign ovw_p   = load_wr && ctrl_q[B_OVW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '1;
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        if (wdata[B_SWR]) ctrl_q <= wdata & SWR_KEEP;
        else              ctrl_q <= wdata & CTRL_MASK;
      end else begin
        ctrl_q[B_SWR] <= 1'b0;
      end

      if (swr_p) begin
        load_q <= '1;
        cmp_q  <= '0;
      end else begin
        if (load_wr) load_q <= wdata[CNT_W_P-1:0];
        if (cmp_wr)  cmp_q  <= wdata[CNT_W_P-1:0];
      end

      if (swr_p)                    flag_q <= 1'b0;
      else if (flag_set)            flag_q <= 1'b1;
      else if (stat_wr && wdata[0]) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pdt_prescaler.sv
module pdt_prescaler
  import pdt_pkg::*;
#(
  parameter int PRE_W_P = PRE_W,
  parameter int NSRC_P  = NSRC,
  parameter int SRC_W_P = SRC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [SRC_W_P-1:0] src_sel,
  input  logic [PRE_W_P-1:0] pre_div,
  input  logic [NSRC_P-1:0]  src_tick,
  output logic               step
);
  logic               sel_tick;
  logic [PRE_W_P-1:0] pcnt;
  logic               wrap;

  always_comb begin
    sel_tick = 1'b0;
    for (int i = 0; i < NSRC_P; i++) begin
      if (src_sel == SRC_W_P'(i + 1)) sel_tick = src_tick[i];
    end
  end

  assign wrap = (pcnt >= pre_div);
  assign step = run && sel_tick && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pcnt <= '0;
    else if (!run)     pcnt <= '0;
    else if (sel_tick) pcnt <= wrap ? '0 : pcnt + 1'b1;
  end
endmodule

// File: rtl/pdt_counter.sv
module pdt_counter
  import pdt_pkg::*;
#(
  parameter int CNT_W_P = CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               ovw,
  input  logic [CNT_W_P-1:0] ovw_val,
  input  logic               start,
  input  logic [CNT_W_P-1:0] start_val,
  input  logic               step,
  input  logic               rld,
  input  logic [CNT_W_P-1:0] load_val,
  input  logic [CNT_W_P-1:0] cmp_val,
  input  logic               cmp_arm,
  output logic [CNT_W_P-1:0] cnt_q,
  output logic               hit
);
  logic [CNT_W_P-1:0] nxt;
  logic               upd;

  always_comb begin
    nxt = cnt_q;
    upd = 1'b0;
    if (clr) begin
      nxt = '0;
    end else if (ovw) begin
      nxt = ovw_val;
      upd = 1'b1;
    end else if (start) begin
      nxt = start_val;
    end else if (step) begin
      upd = 1'b1;
      if (cnt_q == '0) nxt = rld ? load_val : '1;
      else             nxt = cnt_q - 1'b1;
    end
  end

  assign hit = upd && cmp_arm && (nxt == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nxt;
  end
endmodule

// File: rtl/pdt_timer.sv
module pdt_timer
  import pdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [2:0]        src_tick,
  output logic              irq
);
  logic [DATA_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  load_q, cmp_q, cnt_q, start_val;
  logic              flag_q, flag_set, start_p, swr_p, ovw_p, step;

  pdt_regs #(.CNT_W_P(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .flag_set(flag_set), .ctrl_q(ctrl_q), .load_q(load_q), .cmp_q(cmp_q),
    .flag_q(flag_q), .start_p(start_p), .start_val(start_val),
    .swr_p(swr_p), .ovw_p(ovw_p)
  );

  pdt_prescaler #(.PRE_W_P(PRE_W), .NSRC_P(NSRC), .SRC_W_P(SRC_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q[B_EN]),
    .src_sel(ctrl_q[B_SRC_LO +: SRC_W]), .pre_div(ctrl_q[B_PRE_LO +: PRE_W]),
    .src_tick(src_tick), .step(step)
  );

  pdt_counter #(.CNT_W_P(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(swr_p),
    .ovw(ovw_p), .ovw_val(wdata[CNT_W-1:0]),
    .start(start_p), .start_val(start_val),
    .step(step), .rld(ctrl_q[B_RLD]), .load_val(load_q),
    .cmp_val(cmp_q), .cmp_arm(ctrl_q[B_EN] && ctrl_q[B_OCIEN]),
    .cnt_q(cnt_q), .hit(flag_set)
  );

  always_comb begin
    case (addr)
      RA_CTRL: rdata = ctrl_q;
      RA_STAT: rdata = {{(DATA_W-1){1'b0}}, flag_q};
      RA_LOAD: rdata = load_q;
      RA_CMP:  rdata = cmp_q;
      RA_CNT:  rdata = cnt_q;
      default: rdata = '0;
    endcase
  end

  assign irq = flag_q && ctrl_q[B_OCIEN] && ctrl_q[B_EN];
endmodule

// File: rtl/pdt_timer_chk.sv
module pdt_timer_chk #(
  parameter int CNT_W_P = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [2:0]         addr,
  input logic               wd_b0,
  input logic               wd_swr,
  input logic [5:0]         rdata_hi,
  input logic               irq,
  input logic               ctrl_en,
  input logic               ctrl_swr,
  input logic [CNT_W_P-1:0] cnt_q,
  input logic               flag_q
);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd0) |-> (rdata_hi == 6'd0));

  a_r6_swr_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_swr |=> !ctrl_swr);

  a_r6_swr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && wd_swr) |=> (!flag_q && cnt_q == '0));

  a_r5_irq_off_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && !wd_b0) |=> !irq);

  a_r12_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !wr_en) |=> $stable(cnt_q));

  a_r9_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && !wr_en && cnt_q != '0) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !wr_en) |=> flag_q);

  a_r1_cnt_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd4 && !ctrl_en) |=> $stable(cnt_q));
endmodule

bind pdt_timer pdt_timer_chk #(.CNT_W_P(pdt_pkg::CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .wd_b0(wdata[0]), .wd_swr(wdata[16]), .rdata_hi(rdata[31:26]),
  .irq(irq), .ctrl_en(ctrl_q[0]), .ctrl_swr(ctrl_q[16]),
  .cnt_q(cnt_q), .flag_q(flag_q)
);

// File: tb/pdt_timer_test.sv
`timescale 1ns/1ps
module pdt_timer_test;
  localparam logic [31:0] EN = 32'h1, ENMOD = 32'h2, OCIEN = 32'h4, RLD = 32'h8;
  localparam logic [31:0] SWR = 32'h1_0000, OVW = 32'h2_0000, STOP = 32'h20_0000;
  localparam logic [31:0] SRC1 = 32'h0100_0000, SRC2 = 32'h0200_0000;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [2:0]  src_tick = '0;
  logic        irq;
  int checks = 0, errors = 0;

  pdt_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_tick(src_tick), .irq(irq));

  always #2.5 clk = ~clk;

  function automatic logic [31:0] pre(input int n);
    return 32'(n) << 4;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic irq_chk(input string req, input logic exp);
    #1;
    check(req, {31'd0, irq}, {31'd0, exp});
  endtask

  task automatic tick(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); src_tick[idx] = 1'b1;
      @(negedge clk); src_tick[idx] = 1'b0;
    end
  endtask

  task automatic t_reset;
    rd_chk("R7 ctrl", 3'd0, 32'h0);
    rd_chk("R7 status", 3'd1, 32'h0);
    rd_chk("R7 load", 3'd2, 32'hFFFF_FFFF);
    rd_chk("R7 compare", 3'd3, 32'h0);
    rd_chk("R7 count", 3'd4, 32'h0);
    irq_chk("R7 irq", 1'b0);
  endtask

  task automatic t_map;
    wr(3'd0, 32'hFCFE_FFF0);
    rd_chk("R2 ctrl mask", 3'd0, 32'h00FE_FFF0);
    wr(3'd0, 32'h0);
    wr(3'd5, 32'h1234_5678);
    rd_chk("R1 unmapped 5", 3'd5, 32'h0);
    rd_chk("R1 unmapped 7", 3'd7, 32'h0);
    rd_chk("R1 load untouched", 3'd2, 32'hFFFF_FFFF);
    rd_chk("R1 compare untouched", 3'd3, 32'h0);
    wr(3'd4, 32'h55);
    rd_chk("R1 count read-only", 3'd4, 32'h0);
  endtask

  task automatic t_free;
    wr(3'd0, SRC1 | ENMOD | EN);
    rd_chk("R8 start all-ones", 3'd4, 32'hFFFF_FFFF);
    tick(0, 1);
    rd_chk("R9 decrement", 3'd4, 32'hFFFF_FFFE);
    wr(3'd0, SRC1 | ENMOD | EN | OVW);
    wr(3'd2, 32'd2);
    rd_chk("R10 overwrite free", 3'd4, 32'd2);
    tick(0, 2);
    rd_chk("R9 reach zero", 3'd4, 32'd0);
    tick(0, 1);
    rd_chk("R9 wrap all-ones", 3'd4, 32'hFFFF_FFFF);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_reload;
    wr(3'd2, 32'd3);
    rd_chk("R10 no overwrite", 3'd4, 32'hFFFF_FFFF);
    wr(3'd0, SRC1 | RLD | ENMOD | EN);
    rd_chk("R8 start from load", 3'd4, 32'd3);
    tick(0, 3);
    rd_chk("R9 reload zero", 3'd4, 32'd0);
    tick(0, 1);
    rd_chk("R9 reload value", 3'd4, 32'd3);
    wr(3'd0, SRC1 | RLD | ENMOD | EN | OVW);
    wr(3'd2, 32'd7);
    rd_chk("R10 overwrite reload", 3'd4, 32'd7);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_prescale;
    wr(3'd2, 32'd10);
    wr(3'd0, SRC1 | pre(2) | RLD | ENMOD | EN);
    tick(0, 2);
    rd_chk("R3 prescale hold", 3'd4, 32'd10);
    tick(0, 1);
    rd_chk("R3 prescale step", 3'd4, 32'd9);
    tick(1, 3);
    rd_chk("R3 other source ignored", 3'd4, 32'd9);
    tick(0, 3);
    rd_chk("R3 prescale second step", 3'd4, 32'd8);
    wr(3'd0, SRC2 | RLD | EN);
    tick(1, 1);
    rd_chk("R3 source 10", 3'd4, 32'd7);
    wr(3'd0, RLD | EN);
    tick(0, 1); tick(1, 1); tick(2, 1);
    rd_chk("R3 source 00 frozen", 3'd4, 32'd7);
  endtask

  task automatic t_resume;
    wr(3'd0, SRC1 | RLD);
    tick(0, 2);
    rd_chk("R12 hold disabled", 3'd4, 32'd7);
    wr(3'd0, SRC1 | RLD | EN);
    rd_chk("R8 resume held", 3'd4, 32'd7);
    tick(0, 1);
    rd_chk("R8 resume counts", 3'd4, 32'd6);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_compare;
    wr(3'd2, 32'd5);
    wr(3'd3, 32'd3);
    wr(3'd0, SRC1 | RLD | ENMOD | EN | OCIEN);
    tick(0, 1);
    rd_chk("R11 no match yet", 3'd1, 32'd0);
    tick(0, 1);
    rd_chk("R11 match sets flag", 3'd1, 32'd1);
    irq_chk("R5 irq high", 1'b1);
    wr(3'd1, 32'd0);
    rd_chk("R4 write 0 ignored", 3'd1, 32'd1);
    wr(3'd1, 32'd1);
    rd_chk("R4 write 1 clears", 3'd1, 32'd0);
    irq_chk("R5 irq low after clear", 1'b0);
    tick(0, 6);
    rd_chk("R11 match after reload", 3'd1, 32'd1);
    wr(3'd0, SRC1 | RLD | EN);
    irq_chk("R5 irq gated by enable bit 2", 1'b0);
    rd_chk("R5 flag kept", 3'd1, 32'd1);
    wr(3'd0, SRC1 | RLD | EN | OCIEN);
    irq_chk("R5 irq back", 1'b1);
    wr(3'd0, SRC1 | RLD | OCIEN);
    irq_chk("R5 irq gated by enable bit 0", 1'b0);
    wr(3'd1, 32'd1);
    wr(3'd0, SRC1 | RLD | EN);
    tick(0, 6);
    rd_chk("R11 no set without interrupt enable", 3'd1, 32'd0);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_swr;
    wr(3'd3, 32'd9);
    wr(3'd0, SRC1 | RLD | EN | OCIEN | OVW);
    wr(3'd2, 32'd9);
    rd_chk("R11 overwrite match", 3'd1, 32'd1);
    wr(3'd0, SWR | STOP | EN | ENMOD | OCIEN | RLD | pre(5) | SRC1 | OVW);
    rd_chk("R6 ctrl kept bits", 3'd0, 32'h0021_0003);
    rd_chk("R6 status cleared", 3'd1, 32'd0);
    rd_chk("R6 load all-ones", 3'd2, 32'hFFFF_FFFF);
    rd_chk("R6 compare cleared", 3'd3, 32'd0);
    rd_chk("R6 count cleared", 3'd4, 32'd0);
    irq_chk("R6 irq low", 1'b0);
    @(negedge clk);
    rd_chk("R6 reset bit self-clears", 3'd0, 32'h0020_0003);
    tick(0, 2);
    rd_chk("R6 source cleared frozen", 3'd4, 32'd0);
    wr(3'd0, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_free();
    t_reload();
    t_prescale();
    t_resume();
    t_compare();
    t_swr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule